// File: doc/BRIEF.md
# Line-Split Wide Load Coalescer

This block sits between a load/store queue and a data cache port. It accepts one wide load at a time, given as a byte address and a byte count of up to one full vector register (128 bytes by default). If the bytes fit inside a single 64-byte cacheline, the block sends one request to the cache. If they cross one or more line boundaries, it cuts the access into pieces, one per line touched, and sends them in ascending address order.

Each piece carries a small index tag. Cache responses may come back in any order. The block writes each response into a merge buffer at that piece's offset from the original start address. Only when every piece has returned does it present one contiguous result, ready for vector register writeback. The result stays on the output until the consumer takes it. No new load is accepted until then.

Top module: `lsplit_loader`

## Requirements
- R1: Every issued fragment lies inside one 64-byte line: frag_addr[5:0] + frag_len <= 64, and frag_len is never zero.
- R2: An access that stays inside one line yields exactly one fragment with tag 0, whose address and length equal the request's.
- R3: A line-crossing access yields one fragment per line touched, with tags 0, 1, 2 in address order. The first fragment starts at req_addr with length min(req_len, 64 - req_addr[5:0]). Each later fragment starts at the next line-aligned address. The last fragment takes the remaining bytes.
- R4: A 128-byte load at a line-aligned address A yields exactly two 64-byte fragments, at A and A+64.
- R5: While frag_ready is high, one fragment is issued per cycle in ascending address order. While frag_ready is low, frag_valid, frag_addr, frag_len and frag_tag hold steady.
- R6: done_valid stays low until every fragment of the access has a response. It rises in the cycle after the last response is sampled, and it is never high together with frag_valid.
- R7: Responses are accepted in any order. Byte j of rsp_data, for a response with tag t, lands in done_data byte (offset of fragment t from req_addr) + j. done_data byte k sits at bits [8k+7:8k] and holds the memory byte at req_addr+k. Bytes at k >= req_len read as zero, and rsp_data bytes beyond the fragment length are discarded.
- R8: A response is ignored, with no effect on done_data or on completion timing, in any of these cases: its tag was already answered, its tag has not been issued yet, its tag is at or above the fragment count, or no access is in progress.
- R9: req_ready is high only when idle. It stays low from acceptance until done_valid and done_ready are both high. While done_ready is low, done_data and done_len hold steady.
- R10: A zero-length request is accepted, issues no fragment, and raises done_valid in the next cycle with done_len 0 and all-zero done_data.
- R11: With rst_n low at a clock edge, the block returns to idle: req_ready high, frag_valid low, done_valid low. Any access in progress is dropped, and the next access completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Wide load request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | ADDR_W (32) | Start byte address |
| req_len | input | LEN_W (8) | Byte count, 0 to MAX_BYTES |
| frag_valid | output | 1 | Fragment request to the cache is valid |
| frag_ready | input | 1 | Cache port accepts the fragment |
| frag_addr | output | ADDR_W (32) | Fragment start byte address |
| frag_len | output | FLEN_W (7) | Fragment byte count, 1 to 64 |
| frag_tag | output | TAG_W (2) | Fragment index within the access |
| rsp_valid | input | 1 | Fragment data returned |
| rsp_tag | input | TAG_W (2) | Index of the returned fragment |
| rsp_data | input | 8*LINE_BYTES (512) | Fragment bytes, byte 0 = byte at frag_addr |
| done_valid | output | 1 | Merged result available |
| done_ready | input | 1 | Consumer takes the result |
| done_data | output | 8*MAX_BYTES (1024) | Merged bytes in address order |
| done_len | output | LEN_W (8) | Byte count of the completed access |

## Verification
The hardest state to reach from the ports is a busy access with some pieces answered and others still pending, while a stray response arrives. The stray response may repeat an answered tag, name a tag not yet issued, or carry a tag past the fragment count. To get there, the bench's cache model answers in issue order or holds every answer until the last piece has left, with the cache port alternating ready. An injector swaps one genuine answer for a stray one that carries poison data. Both the merged bytes and the completion cycle must then show no trace of the stray response.

// File: rtl/lsplit_pkg.sv
// Shared types for the line-split wide load coalescer.
package lsplit_pkg;

    // Controller phases: waiting for a load, moving fragments, holding the result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } lsplit_state_e;

endpackage

// File: rtl/lsplit_plan.sv
// Fragment planner (combinational).
// For fragment index idx_i of an access (base_i, len_i), returns the
// fragment's start address, its byte offset from the access start, and its
// byte count.
// Assumes: LINE_BYTES is a power of two, and idx_i is below the fragment
// count of the access. Outputs for larger indices are not meaningful.
module lsplit_plan #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int OFS_W      = 6,
    parameter int LEN_W      = 8,
    parameter int OFF_W      = 9,
    parameter int TAG_W      = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [TAG_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [OFF_W-1:0]  flen_o
);
    localparam int LW = ADDR_W - OFS_W;

    logic [OFF_W-1:0] head_len;
    logic [OFF_W-1:0] cap;
    logic [OFF_W-1:0] remain;

    // Head piece runs to the end of the start line; later pieces are whole lines.
    always_comb begin
        head_len = OFF_W'(LINE_BYTES) - OFF_W'(base_i[OFS_W-1:0]);
        if (idx_i == '0) begin
            off_o  = '0;
            cap    = head_len;
            addr_o = base_i;
        end else begin
            off_o  = head_len + OFF_W'(LINE_BYTES) * (OFF_W'(idx_i) - OFF_W'(1));
            cap    = OFF_W'(LINE_BYTES);
            addr_o = {base_i[ADDR_W-1:OFS_W] + LW'(idx_i), OFS_W'(0)};
        end
        remain = OFF_W'(len_i) - off_o;
        flen_o = (remain < cap) ? remain : cap;
    end

endmodule

// File: rtl/lsplit_track.sv
// Fragment progress tracker.
// Counts issued fragments, records which tags have returned, and counts
// accepted responses. Everything clears on reset and at each new access.
// Assumes: take_i is raised only for a tag not yet recorded.
module lsplit_track #(
    parameter int TAG_W = 2,
    parameter int CNT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 issue_i,
    input  logic                 take_i,
    input  logic [TAG_W-1:0]     take_tag_i,
    output logic [CNT_W-1:0]     issued_o,
    output logic [(1<<TAG_W)-1:0] got_o,
    output logic [CNT_W-1:0]     got_cnt_o
);
    localparam int SLOTS = 1 << TAG_W;

    // Number of fragments handed to the cache so far.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) issued_o <= '0;
        else if (issue_i)      issued_o <= issued_o + CNT_W'(1);
    end

    // Number of fragments whose data has been merged.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) got_cnt_o <= '0;
        else if (take_i)       got_cnt_o <= got_cnt_o + CNT_W'(1);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Per-tag flag: this fragment's data has arrived.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)                         got_o[s] <= 1'b0;
            else if (take_i && take_tag_i == TAG_W'(s))    got_o[s] <= 1'b1;
        end
    end

endmodule

// File: rtl/lsplit_merge.sv
// Merge buffer.
// Holds the bytes of one wide access. A write places the first len_i bytes
// of data_i starting at byte off_i. Bytes never written stay zero after clear.
// Assumes: off_i + len_i <= MAX_BYTES whenever wr_i is high.
module lsplit_merge #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    parameter int OFF_W      = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    wr_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic [OFF_W-1:0]        len_i,
    input  logic [LINE_BYTES*8-1:0] data_i,
    output logic [MAX_BYTES*8-1:0]  buf_o
);
    localparam int DB = LINE_BYTES * 8;
    localparam int BB = MAX_BYTES * 8;
    localparam int EB = BB + DB;
    localparam int EM = MAX_BYTES + LINE_BYTES;

    logic [LINE_BYTES-1:0] lane_mask;
    logic [EB-1:0]         ext_data;
    logic [EM-1:0]         ext_mask;
    logic [BB-1:0]         place_data;
    logic [MAX_BYTES-1:0]  place_mask;
    logic [7:0]            bytes_q [MAX_BYTES];

    for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lane
        // Lane j of the response carries a valid byte.
        assign lane_mask[j] = (OFF_W'(j) < len_i);
    end

    // Slide the response and its lane mask up to the fragment's offset.
    assign ext_data   = {{BB{1'b0}}, data_i};
    assign ext_mask   = {{MAX_BYTES{1'b0}}, lane_mask};
    assign place_data = BB'(ext_data << {off_i, 3'b000});
    assign place_mask = MAX_BYTES'(ext_mask << off_i);

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        // Byte b: clear on a new access, load when a response covers it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)          bytes_q[b] <= 8'h00;
            else if (wr_i && place_mask[b]) bytes_q[b] <= place_data[b*8 +: 8];
        end
        assign buf_o[b*8 +: 8] = bytes_q[b];
    end

endmodule

// File: rtl/lsplit_loader.sv
// Line-split wide load coalescer (top).
// Accepts one wide load, cuts it at line boundaries into tagged fragments,
// merges the tagged responses in any order, and presents one result.
// Assumes: the cache returns each issued tag exactly once with the bytes
// starting at the fragment address; req_len <= MAX_BYTES; LINE_BYTES is a
// power of two.
module lsplit_loader
    import lsplit_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_BYTES = 64,
    parameter  int MAX_BYTES  = 128,
    localparam int OFS_W      = $clog2(LINE_BYTES),
    localparam int LEN_W      = $clog2(MAX_BYTES + 1),
    localparam int FLEN_W     = OFS_W + 1,
    localparam int FRAG_MAX   = (MAX_BYTES + 2 * LINE_BYTES - 2) / LINE_BYTES,
    localparam int TAG_W      = (FRAG_MAX > 1) ? $clog2(FRAG_MAX) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    output logic                    frag_valid,
    input  logic                    frag_ready,
    output logic [ADDR_W-1:0]       frag_addr,
    output logic [FLEN_W-1:0]       frag_len,
    output logic [TAG_W-1:0]        frag_tag,
    input  logic                    rsp_valid,
    input  logic [TAG_W-1:0]        rsp_tag,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    output logic                    done_valid,
    input  logic                    done_ready,
    output logic [MAX_BYTES*8-1:0]  done_data,
    output logic [LEN_W-1:0]        done_len
);
    localparam int CNT_W = $clog2(FRAG_MAX + 1);
    localparam int OFF_W = LEN_W + 1;
    localparam int SLOTS = 1 << TAG_W;

    lsplit_state_e     state_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  nfrag_q;
    logic [CNT_W-1:0]  nfrag_calc;
    logic [CNT_W-1:0]  issued;
    logic [CNT_W-1:0]  got_cnt;
    logic [SLOTS-1:0]  got;
    logic              accept;
    logic              issue_fire;
    logic              rsp_ok;
    logic              last_in;
    logic [ADDR_W-1:0] iss_addr;
    logic [OFF_W-1:0]  iss_off;
    logic [OFF_W-1:0]  iss_flen;
    logic [ADDR_W-1:0] rsp_addr;
    logic [OFF_W-1:0]  rsp_off;
    logic [OFF_W-1:0]  rsp_flen;

    // Number of lines touched by the incoming request.
    always_comb begin
        nfrag_calc = CNT_W'((int'(req_addr[OFS_W-1:0]) + int'(req_len) + LINE_BYTES - 1)
                            / LINE_BYTES);
    end

    // Handshakes and response filtering.
    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign frag_valid = (state_q == ST_BUSY) && (issued < nfrag_q);
    assign issue_fire = frag_valid && frag_ready;
    assign rsp_ok     = (state_q == ST_BUSY) && rsp_valid
                        && (int'(rsp_tag) < int'(issued)) && !got[rsp_tag];
    assign last_in    = rsp_ok && (int'(got_cnt) + 1 == int'(nfrag_q));

    // Control state and the latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            len_q   <= '0;
            nfrag_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    base_q  <= req_addr;
                    len_q   <= req_len;
                    nfrag_q <= nfrag_calc;
                    state_q <= (req_len == '0) ? ST_DONE : ST_BUSY;
                end
                ST_BUSY: if (last_in)    state_q <= ST_DONE;
                ST_DONE: if (done_ready) state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Planner for the next fragment to issue.
    lsplit_plan #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .OFS_W(OFS_W),
        .LEN_W(LEN_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
    ) u_plan_issue (
        .base_i(base_q), .len_i(len_q), .idx_i(TAG_W'(issued)),
        .addr_o(iss_addr), .off_o(iss_off), .flen_o(iss_flen)
    );

    // Planner for the fragment named by the incoming response.
    lsplit_plan #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .OFS_W(OFS_W),
        .LEN_W(LEN_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
    ) u_plan_rsp (
        .base_i(base_q), .len_i(len_q), .idx_i(rsp_tag),
        .addr_o(rsp_addr), .off_o(rsp_off), .flen_o(rsp_flen)
    );

    lsplit_track #(
        .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .clear_i(accept),
        .issue_i(issue_fire), .take_i(rsp_ok), .take_tag_i(rsp_tag),
        .issued_o(issued), .got_o(got), .got_cnt_o(got_cnt)
    );

    lsplit_merge #(
        .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W)
    ) u_merge (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .wr_i(rsp_ok),
        .off_i(rsp_off), .len_i(rsp_flen), .data_i(rsp_data), .buf_o(done_data)
    );

    // Port outputs.
    assign req_ready  = (state_q == ST_IDLE);
    assign frag_addr  = iss_addr;
    assign frag_len   = FLEN_W'(iss_flen);
    assign frag_tag   = TAG_W'(issued);
    assign done_valid = (state_q == ST_DONE);
    assign done_len   = len_q;

    // Planner outputs not needed on this side: the response side needs no
    // address, and the issue side needs no offset.
    logic unused_plan;
    assign unused_plan = ^{rsp_addr, iss_off};

endmodule

// File: rtl/lsplit_checks.sv
// Protocol checker for lsplit_loader, bound to every instance.
// Observes ports only. Assumes the same parameters as the bound instance.
module lsplit_checks #(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_BYTES = 64,
    parameter  int MAX_BYTES  = 128,
    localparam int OFS_W      = $clog2(LINE_BYTES),
    localparam int LEN_W      = $clog2(MAX_BYTES + 1),
    localparam int FLEN_W     = OFS_W + 1,
    localparam int FRAG_MAX   = (MAX_BYTES + 2 * LINE_BYTES - 2) / LINE_BYTES,
    localparam int TAG_W      = (FRAG_MAX > 1) ? $clog2(FRAG_MAX) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [LEN_W-1:0]       req_len,
    input logic                   frag_valid,
    input logic                   frag_ready,
    input logic [ADDR_W-1:0]      frag_addr,
    input logic [FLEN_W-1:0]      frag_len,
    input logic [TAG_W-1:0]       frag_tag,
    input logic                   done_valid,
    input logic                   done_ready,
    input logic [MAX_BYTES*8-1:0] done_data,
    input logic [LEN_W-1:0]       done_len
);

    AST_FRAG_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (int'(frag_addr[OFS_W-1:0]) + int'(frag_len) <= LINE_BYTES)
                       && (frag_len != '0)); // R1

    AST_FRAG_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_ready) |=> (!frag_valid || (frag_addr > $past(frag_addr)))); // R5

    AST_FRAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready) |=> frag_valid && $stable(frag_addr)
                                        && $stable(frag_len) && $stable(frag_tag)); // R5

    AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !frag_valid); // R6

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ready) |=> done_valid && $stable(done_data)
                                        && $stable(done_len)); // R9

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> done_valid && !frag_valid); // R10

endmodule

bind lsplit_loader lsplit_checks #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_addr(frag_addr), .frag_len(frag_len), .frag_tag(frag_tag),
    .done_valid(done_valid), .done_ready(done_ready), .done_data(done_data),
    .done_len(done_len)
);

// File: tb/lsplit_loader_tb.sv
// Bench for lsplit_loader. A behavioural model (queues of fragments,
// outstanding list, byte array) predicts every output and is compared at
// every falling edge. Inputs change only at falling edges.
module lsplit_loader_tb_top;
    localparam int CLK_NS = 10;
    localparam int LB     = 64;
    localparam int MB     = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic [7:0]    req_len = '0;
    logic          frag_valid;
    logic          frag_ready = 1'b0;
    logic [31:0]   frag_addr;
    logic [6:0]    frag_len;
    logic [1:0]    frag_tag;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_tag = '0;
    logic [511:0]  rsp_data = '0;
    logic          done_valid;
    logic          done_ready = 1'b0;
    logic [1023:0] done_data;
    logic [7:0]    done_len;

    always #(CLK_NS/2) clk = ~clk;

    lsplit_loader dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
        .frag_len(frag_len), .frag_tag(frag_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .done_valid(done_valid), .done_ready(done_ready), .done_data(done_data),
        .done_len(done_len)
    );

    // model state
    int m_state = 0;                 // 0 idle, 1 busy, 2 done
    int q_addr[$], q_len[$], q_tag[$];
    int o_addr[$], o_len[$], o_tag[$];
    int answered[$];
    int m_nfrag = 0, m_rcvd = 0, m_len = 0;
    logic [1023:0] m_data = '0;
    // stimulus control
    int pend = 0, p_addr = 0, p_len = 0;
    int rdy_mode = 0, rsp_mode = 0, dhold = 0, inj_kind = 0, inj_done = 0;
    int cyc = 0, in_reset = 1;
    // observation
    int seen_addr[$], seen_len[$];
    int done_cycles = 0;
    logic [1023:0] last_done = '0, exp_last = '0;
    int last_len = -1;
    int total = 0, bad = 0;

    function automatic logic [7:0] memb(input int a);
        return 8'((a * 29) + (a >>> 7) + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chkw(input bit ok, input string req, input string what,
                        input logic [1023:0] act, input logic [1023:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model: accept a request and plan its fragments.
    task automatic model_accept(input int a, input int l);
        int off, i, fa, fl, cap;
        q_addr.delete(); q_len.delete(); q_tag.delete();
        o_addr.delete(); o_len.delete(); o_tag.delete(); answered.delete();
        m_len = l; m_rcvd = 0; m_data = '0;
        for (int k = 0; k < l; k++) m_data[k*8 +: 8] = memb(a + k);
        off = 0; i = 0; fa = a;
        while (off < l) begin
            cap = (i == 0) ? (LB - (a % LB)) : LB;
            fl  = (l - off < cap) ? (l - off) : cap;
            q_addr.push_back(fa); q_len.push_back(fl); q_tag.push_back(i);
            off += fl; i++;
            fa = ((a / LB) + i) * LB;
        end
        m_nfrag = i;
        m_state = (l == 0) ? 2 : 1;
    endtask

    // One cycle: compare at the falling edge, drive, update the model.
    task automatic tick();
        bit exp_fv, genuine, f_req, f_frag, f_done;
        int sel;
        logic [511:0] d;
        @(negedge clk);
        if (in_reset == 0) begin
            chk(req_ready === (m_state == 0), "R9", "req_ready", longint'(req_ready), longint'(m_state == 0));
            chk(done_valid === (m_state == 2), "R6", "done_valid", longint'(done_valid), longint'(m_state == 2));
            exp_fv = (m_state == 1) && (q_addr.size() > 0);
            chk(frag_valid === exp_fv, "R5", "frag_valid", longint'(frag_valid), longint'(exp_fv));
            if (exp_fv && frag_valid) begin
                chk(frag_addr == 32'(q_addr[0]), "R3", "frag_addr", longint'(frag_addr), longint'(q_addr[0]));
                chk(frag_len == 7'(q_len[0]), "R3", "frag_len", longint'(frag_len), longint'(q_len[0]));
                chk(frag_tag == 2'(q_tag[0]), "R3", "frag_tag", longint'(frag_tag), longint'(q_tag[0]));
                chk(int'(frag_addr[5:0]) + int'(frag_len) <= LB && frag_len != 0, "R1",
                    "frag_in_line", longint'(frag_addr[5:0]) + longint'(frag_len), LB);
            end
            if (done_valid) done_cycles++;
            if (m_state == 2 && done_valid) begin
                chkw(done_data === m_data, "R7", "done_data", done_data, m_data);
                chk(done_len == 8'(m_len), "R7", "done_len", longint'(done_len), longint'(m_len));
            end
        end
        // drive inputs for the coming edge
        req_valid = (pend != 0);
        req_addr  = 32'(p_addr);
        req_len   = 8'(p_len);
        frag_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;
        if (m_state == 2 && dhold > 0) begin done_ready = 1'b0; dhold--; end
        else done_ready = 1'b1;
        rsp_valid = 1'b0; genuine = 0; sel = -1;
        if (inj_kind == 1 && m_state == 1 && answered.size() > 0) begin
            rsp_valid = 1'b1; rsp_tag = 2'(answered[0]); rsp_data = {64{8'h5A}};
            inj_kind = 0; inj_done++;
        end else if (inj_kind == 2 && m_state == 1 && q_tag.size() > 0) begin
            rsp_valid = 1'b1; rsp_tag = 2'(q_tag[0]); rsp_data = {64{8'h5A}};
            inj_kind = 0; inj_done++;
        end else if (inj_kind == 3 && m_state == 1 && m_nfrag < 4) begin
            rsp_valid = 1'b1; rsp_tag = 2'(m_nfrag); rsp_data = {64{8'h5A}};
            inj_kind = 0; inj_done++;
        end else if (inj_kind == 4 && m_state == 0 && pend == 0) begin
            rsp_valid = 1'b1; rsp_tag = 2'd0; rsp_data = {64{8'h5A}};
            inj_kind = 0; inj_done++;
        end else if (m_state == 1 && o_tag.size() > 0) begin
            if (rsp_mode == 0) sel = 0;
            else if (rsp_mode == 1 && q_addr.size() == 0) sel = o_tag.size() - 1;
            if (sel >= 0) begin
                for (int j = 0; j < LB; j++)
                    d[j*8 +: 8] = (j < o_len[sel]) ? memb(o_addr[sel] + j) : 8'hEE;
                rsp_valid = 1'b1; rsp_tag = 2'(o_tag[sel]); rsp_data = d;
                genuine = 1;
            end
        end
        // handshakes that complete at the coming edge
        f_req  = req_valid && req_ready;
        f_frag = frag_valid && frag_ready;
        f_done = done_valid && done_ready;
        if (genuine) begin
            answered.push_back(o_tag[sel]);
            o_addr.delete(sel); o_len.delete(sel); o_tag.delete(sel);
            m_rcvd++;
        end
        if (f_frag && q_addr.size() > 0) begin
            seen_addr.push_back(q_addr[0]); seen_len.push_back(q_len[0]);
            o_addr.push_back(q_addr.pop_front());
            o_len.push_back(q_len.pop_front());
            o_tag.push_back(q_tag.pop_front());
        end
        if (genuine && m_rcvd == m_nfrag) m_state = 2;
        if (f_done && m_state == 2) begin
            last_done = done_data; last_len = int'(done_len); exp_last = m_data;
            m_state = 0;
        end
        if (f_req && m_state == 0 && pend != 0) begin
            pend = 0;
            model_accept(p_addr, p_len);
        end
        cyc++;
    endtask

    task automatic run_access(input int a, input int l);
        int n = 0;
        seen_addr.delete(); seen_len.delete(); done_cycles = 0;
        pend = 1; p_addr = a; p_len = l;
        do begin tick(); n++; end while (!(pend == 0 && m_state == 0) && n < 600);
        chkw(last_done === exp_last, "R7", "final_data", last_done, exp_last);
    endtask

    task automatic do_reset();
        in_reset = 1; rst_n = 1'b0;
        req_valid = 1'b0; frag_ready = 1'b0; rsp_valid = 1'b0; done_ready = 1'b0; pend = 0;
        repeat (2) @(negedge clk);
        chk(req_ready === 1'b1, "R11", "req_ready_in_reset", longint'(req_ready), 1);
        chk(frag_valid === 1'b0, "R11", "frag_valid_in_reset", longint'(frag_valid), 0);
        chk(done_valid === 1'b0, "R11", "done_valid_in_reset", longint'(done_valid), 0);
        m_state = 0; q_addr.delete(); q_len.delete(); q_tag.delete();
        o_addr.delete(); o_len.delete(); o_tag.delete(); answered.delete();
        rst_n = 1'b1; in_reset = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R2: inside one line, short and full-line
        run_access(32'h100, 16);
        chk(seen_addr.size() == 1, "R2", "frag_count_16", seen_addr.size(), 1);
        chk(seen_addr[0] == 32'h100 && seen_len[0] == 16, "R2", "frag_shape_16", seen_len[0], 16);
        run_access(32'h1C0, 64);
        chk(seen_addr.size() == 1 && seen_len[0] == 64, "R2", "frag_full_line", seen_addr.size(), 1);
        run_access(32'h7F, 1);
        chk(seen_addr.size() == 1 && seen_len[0] == 1, "R2", "frag_last_byte", seen_addr.size(), 1);

        // R4: aligned full vector
        run_access(32'h2000, 128);
        chk(seen_addr.size() == 2, "R4", "frag_count", seen_addr.size(), 2);
        chk(seen_addr[0] == 32'h2000 && seen_addr[1] == 32'h2040, "R4", "frag_addrs", seen_addr[1], 32'h2040);
        chk(seen_len[0] == 64 && seen_len[1] == 64, "R4", "frag_lens", seen_len[1], 64);

        // R3: crossings with short head
        run_access(32'h13C, 40);
        chk(seen_addr.size() == 2 && seen_len[0] == 4 && seen_len[1] == 36, "R3", "split_4_36", seen_len[0], 4);
        chk(seen_addr[1] == 32'h140, "R3", "second_aligned", seen_addr[1], 32'h140);
        run_access(32'h3F, 2);
        chk(seen_addr.size() == 2 && seen_len[0] == 1 && seen_len[1] == 1, "R3", "split_1_1", seen_addr.size(), 2);

        // R3 R5 R7: three pieces, cache stalls alternate, answers reversed
        rdy_mode = 1; rsp_mode = 1;
        run_access(32'h3021, 128);
        chk(seen_addr.size() == 3, "R3", "three_pieces", seen_addr.size(), 3);
        chk(seen_len[0] == 31 && seen_len[1] == 64 && seen_len[2] == 33, "R3", "lens_31_64_33", seen_len[2], 33);
        chk(last_len == 128, "R7", "len_reversed", last_len, 128);
        rdy_mode = 0; rsp_mode = 0;

        // R10: zero-length
        run_access(32'h4444, 0);
        chk(seen_addr.size() == 0, "R10", "no_fragments", seen_addr.size(), 0);
        chkw(last_done === '0, "R10", "zero_data", last_done, '0);
        chk(last_len == 0 && done_cycles == 1, "R10", "done_next_cycle", done_cycles, 1);

        // R9: consumer stalls
        dhold = 4;
        run_access(32'h500, 80);
        chk(done_cycles == 5, "R9", "done_held", done_cycles, 5);

        // R8: stray responses
        inj_done = 0;
        inj_kind = 1; run_access(32'h3021, 128);
        chkw(last_done === exp_last, "R8", "dup_tag_ignored", last_done, exp_last);
        inj_kind = 2; rdy_mode = 1; run_access(32'h3021, 128); rdy_mode = 0;
        chkw(last_done === exp_last, "R8", "unissued_ignored", last_done, exp_last);
        inj_kind = 3; run_access(32'h13C, 40);
        chkw(last_done === exp_last, "R8", "range_ignored", last_done, exp_last);
        inj_kind = 4; repeat (3) tick();
        run_access(32'h900, 8);
        chk(inj_done == 4, "R8", "injections", inj_done, 4);

        // R11: reset in the middle of an access
        rsp_mode = 2; pend = 1; p_addr = 32'h5010; p_len = 100;
        repeat (6) tick();
        do_reset();
        rsp_mode = 0;
        run_access(32'h6010, 100);
        chk(seen_addr.size() == 2 && seen_len[0] == 48 && seen_len[1] == 52, "R11", "after_reset", seen_len[0], 48);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule